// File: doc/BRIEF.md
# Code-Select Multi-Code Spreader

This block is the baseband half of a direct-sequence spread-spectrum transmitter. In it the message bits pick which spreading code goes out. It does not multiply one fixed pseudo-noise code by each bit. The message arrives one bit at a time on a valid/ready stream. Depending on the mode, the block collects 1, 2 or 3 bits into a symbol index, with the first bit in the most significant position. The index selects one of 2, 4 or 8 entries in an 11-chip code bank. That entry then goes out chip by chip, and no data bit is mixed into it.

Each chip is presented in polar form, +1 or -1. A phase-select flag tells a downstream carrier multiplexer to pass either the carrier or its negation. A chip strobe marks the cycles that carry a chip. A symbol-start flag marks chip 0 of every code, so a receiver can align to it.

Back-pressure works in two stages. The input accepts bits only while no complete symbol is waiting. A waiting symbol is taken in the cycle after the 11th chip of the symbol in flight, so codes follow one another without a gap while data keeps up. A host fills the code bank through a small address/data port while the spreader is idle. Software must keep the codes mutually uncorrelated and secret.

Top module: `mcode_spreader`

## Requirements
- R1: Every symbol goes out as exactly 11 consecutive strobed chips. These are the bits of the selected bank word, sent from bit 10 down to bit 0, with no data bit combined into them.
- R2: `mode_i` = 1, 2 or 3 selects 1, 2 or 3 bits per symbol, which address bank entries 0..1, 0..3 or 0..7. The value 0 behaves as 1.
- R3: The bits of a symbol are gathered most significant first: the first accepted bit of a symbol becomes the highest bit of its index.
- R4: `chip_o` is a 2-bit signed value. It is +1 (2'b01) for a code bit of 1 and -1 (2'b11) for a code bit of 0 while `chip_stb_o` is high, and 0 while it is low.
- R5: `phase_sel_o` is high exactly when a strobed chip is -1, and low otherwise.
- R6: The mode is sampled when the first bit of a symbol is accepted. A change made later in that symbol applies only from the next symbol.
- R7: A new symbol starts only in the cycle after the 11th chip of the current one, and directly follows it when already complete. `msg_ready_o` is low while a complete symbol waits.
- R8: If no complete symbol is waiting when a symbol ends, the strobe drops, `chip_o` returns to 0 and the previous code is not repeated.
- R9: `sym_start_o` is high on chip 0 of each symbol and on no other cycle.
- R10: A bank write while `chip_stb_o` is low stores `cfg_code_i` at `cfg_addr_i`. A write while `chip_stb_o` is high is ignored.
- R11: After reset the strobe and symbol-start are low, `msg_ready_o` is high and every bank entry holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bits per symbol (0 and 1 mean one bit) |
| msg_bit_i | input | 1 | Message bit |
| msg_valid_i | input | 1 | Message bit is valid |
| msg_ready_o | output | 1 | Spreader accepts a message bit |
| cfg_we_i | input | 1 | Code bank write strobe |
| cfg_addr_i | input | 3 | Code bank entry |
| cfg_code_i | input | 11 | Code word, bit 10 sent first |
| chip_o | output | 2 | Signed polar chip: +1, -1, or 0 when idle |
| phase_sel_o | output | 1 | Select negated carrier |
| chip_stb_o | output | 1 | Chip present this cycle |
| sym_start_o | output | 1 | Chip 0 of a code |

## Verification
Symbol streams are run in each mode with index patterns whose codes differ. A wrong bit order or a wrong index width shows up as a different code word than expected. A continuous feed in three-bit mode tells back-to-back chaining apart from gaps and from early symbol loading. It also shows the input held off while a symbol waits. A mode change in the middle of a symbol separates mode latching at the first bit from live mode use. Writes made during and between transmissions, followed by sends that select those entries, tell an ignored write from an accepted one. A drained stream shows whether the output goes idle or repeats the last code.

// File: rtl/mcode_spreader_pkg.sv
package mcode_spreader_pkg;
  localparam int unsigned SPR_CHIPS    = 11;
  localparam int unsigned SPR_MAX_BITS = 3;

  // mode value to bits per symbol, clamped to [1, max_bits]
  function automatic int unsigned bits_for_mode(input logic [1:0] m, input int unsigned max_bits);
    int unsigned b;
    b = (m == 2'd0) ? 1 : int'(m);
    if (b > max_bits) b = max_bits;
    return b;
  endfunction
endpackage

// File: rtl/spr_bit_gather.sv
module spr_bit_gather
  import mcode_spreader_pkg::*;
#(
  parameter int unsigned MAX_BITS = SPR_MAX_BITS,
  localparam int unsigned CNTW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                bit_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic                take_i,
  output logic                sym_valid_o,
  output logic [MAX_BITS-1:0] sym_idx_o
);
  logic [CNTW-1:0]     cnt_q;
  logic [CNTW-1:0]     need_q;
  logic [CNTW-1:0]     need_now;
  logic [MAX_BITS-1:0] idx_q;
  logic                full_q;
  logic                accept;

  assign ready_o     = !full_q;
  assign accept      = valid_i && !full_q;
  assign sym_valid_o = full_q;
  assign sym_idx_o   = idx_q;
  assign need_now    = (cnt_q == '0) ? CNTW'(bits_for_mode(mode_i, MAX_BITS)) : need_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      need_q <= CNTW'(1);
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (accept) begin
        if (cnt_q == '0) begin
          need_q <= need_now;
          idx_q  <= {{(MAX_BITS-1){1'b0}}, bit_i};
        end else begin
          idx_q  <= {idx_q[MAX_BITS-2:0], bit_i};
        end
        if (CNTW'(cnt_q + 1'b1) == need_now) begin
          cnt_q  <= '0;
          full_q <= 1'b1;
        end else begin
          cnt_q  <= CNTW'(cnt_q + 1'b1);
        end
      end
    end
  end
endmodule

// File: rtl/spr_code_bank.sv
module spr_code_bank
  import mcode_spreader_pkg::*;
#(
  parameter int unsigned CHIPS    = SPR_CHIPS,
  parameter int unsigned MAX_BITS = SPR_MAX_BITS,
  localparam int unsigned NCODES  = 1 << MAX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy_i,
  input  logic                we_i,
  input  logic [MAX_BITS-1:0] waddr_i,
  input  logic [CHIPS-1:0]    wdata_i,
  input  logic [MAX_BITS-1:0] raddr_i,
  output logic [CHIPS-1:0]    rdata_o
);
  logic [CHIPS-1:0] entry_q [NCODES];

  for (genvar k = 0; k < NCODES; k++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q[k] <= '0;
      else if (we_i && !busy_i && (waddr_i == MAX_BITS'(k))) entry_q[k] <= wdata_i;
    end
  end

  assign rdata_o = entry_q[raddr_i];
endmodule

// File: rtl/spr_chip_seq.sv
module spr_chip_seq
  import mcode_spreader_pkg::*;
#(
  parameter int unsigned CHIPS = SPR_CHIPS,
  localparam int unsigned CW   = $clog2(CHIPS),
  localparam logic [CW-1:0] LAST = CW'(CHIPS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid_i,
  input  logic [CHIPS-1:0] word_i,
  output logic             take_o,
  output logic             active_o,
  output logic             first_o,
  output logic             chip_bit_o
);
  logic             active_q;
  logic [CW-1:0]    pos_q;
  logic [CHIPS-1:0] sh_q;

  assign take_o     = sym_valid_i && (!active_q || pos_q == LAST);
  assign active_o   = active_q;
  assign first_o    = active_q && (pos_q == '0);
  assign chip_bit_o = sh_q[CHIPS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      sh_q     <= '0;
    end else if (take_o) begin
      active_q <= 1'b1;
      pos_q    <= '0;
      sh_q     <= word_i;
    end else if (active_q) begin
      if (pos_q == LAST) begin
        active_q <= 1'b0;
        pos_q    <= '0;
      end else begin
        pos_q <= CW'(pos_q + 1'b1);
        sh_q  <= {sh_q[CHIPS-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spr_polar_map.sv
module spr_polar_map (
  input  logic              active_i,
  input  logic              bit_i,
  output logic signed [1:0] chip_o,
  output logic              neg_o
);
  always_comb begin
    if (!active_i) begin
      chip_o = 2'sd0;
      neg_o  = 1'b0;
    end else if (bit_i) begin
      chip_o = 2'sd1;
      neg_o  = 1'b0;
    end else begin
      chip_o = -2'sd1;
      neg_o  = 1'b1;
    end
  end
endmodule

// File: rtl/mcode_spreader.sv
module mcode_spreader
  import mcode_spreader_pkg::*;
#(
  parameter int unsigned CHIPS    = SPR_CHIPS,
  parameter int unsigned MAX_BITS = SPR_MAX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                msg_bit_i,
  input  logic                msg_valid_i,
  output logic                msg_ready_o,
  input  logic                cfg_we_i,
  input  logic [MAX_BITS-1:0] cfg_addr_i,
  input  logic [CHIPS-1:0]    cfg_code_i,
  output logic signed [1:0]   chip_o,
  output logic                phase_sel_o,
  output logic                chip_stb_o,
  output logic                sym_start_o
);
  logic                sym_valid;
  logic [MAX_BITS-1:0] sym_idx;
  logic                take;
  logic [CHIPS-1:0]    word;
  logic                active;
  logic                first;
  logic                chip_bit;

  spr_bit_gather #(.MAX_BITS(MAX_BITS)) u_gather (
    .clk, .rst_n, .mode_i,
    .bit_i(msg_bit_i), .valid_i(msg_valid_i), .ready_o(msg_ready_o),
    .take_i(take), .sym_valid_o(sym_valid), .sym_idx_o(sym_idx)
  );

  spr_code_bank #(.CHIPS(CHIPS), .MAX_BITS(MAX_BITS)) u_bank (
    .clk, .rst_n, .busy_i(active),
    .we_i(cfg_we_i), .waddr_i(cfg_addr_i), .wdata_i(cfg_code_i),
    .raddr_i(sym_idx), .rdata_o(word)
  );

  spr_chip_seq #(.CHIPS(CHIPS)) u_seq (
    .clk, .rst_n, .sym_valid_i(sym_valid), .word_i(word),
    .take_o(take), .active_o(active), .first_o(first), .chip_bit_o(chip_bit)
  );

  spr_polar_map u_map (
    .active_i(active), .bit_i(chip_bit), .chip_o(chip_o), .neg_o(phase_sel_o)
  );

  assign chip_stb_o  = active;
  assign sym_start_o = first;
endmodule

// File: rtl/mcode_spreader_chk.sv
module mcode_spreader_chk #(
  parameter int unsigned CHIPS = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic signed [1:0] chip_o,
  input logic              phase_sel_o,
  input logic              chip_stb_o,
  input logic              sym_start_o
);
  localparam int unsigned RW = $clog2(CHIPS + 2);
  logic [RW-1:0] run_q;
  logic          prev_stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= '0;
      prev_stb_q <= 1'b0;
    end else begin
      prev_stb_q <= chip_stb_o;
      if (chip_stb_o) run_q <= sym_start_o ? RW'(1) : RW'(run_q + 1'b1);
    end
  end

  a_r4_polar_level: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb_o |-> (chip_o == 2'sd1 || chip_o == -2'sd1));
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_stb_o |-> chip_o == 2'sd0);
  a_r5_phase_sign: assert property (@(posedge clk) disable iff (!rst_n)
    phase_sel_o == (chip_stb_o && chip_o == -2'sd1));
  a_r9_start_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start_o |-> chip_stb_o);
  a_r9_rise_is_start: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_stb_o && !prev_stb_q) |-> sym_start_o);
  a_r7_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_start_o && prev_stb_q) |-> run_q == RW'(CHIPS));
  a_r1_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_stb_o && !sym_start_o) |-> (run_q < RW'(CHIPS) && run_q != '0));
  a_r8_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_stb_o && prev_stb_q) |-> run_q == RW'(CHIPS));
endmodule

bind mcode_spreader mcode_spreader_chk #(.CHIPS(CHIPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_o(chip_o), .phase_sel_o(phase_sel_o),
  .chip_stb_o(chip_stb_o), .sym_start_o(sym_start_o)
);

// File: tb/mcode_spreader_test.sv
module mcode_spreader_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode_i = 2'd1;
  logic              msg_bit_i = 1'b0;
  logic              msg_valid_i = 1'b0;
  logic              msg_ready_o;
  logic              cfg_we_i = 1'b0;
  logic [2:0]        cfg_addr_i = '0;
  logic [10:0]       cfg_code_i = '0;
  logic signed [1:0] chip_o;
  logic              phase_sel_o;
  logic              chip_stb_o;
  logic              sym_start_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [10:0] exp_bank [8];

  mcode_spreader uut (
    .clk, .rst_n, .mode_i, .msg_bit_i, .msg_valid_i, .msg_ready_o,
    .cfg_we_i, .cfg_addr_i, .cfg_code_i,
    .chip_o, .phase_sel_o, .chip_stb_o, .sym_start_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] mk_code(input int k);
    return 11'h712 ^ (11'(k) * 11'h0A5);
  endfunction

  task automatic send_bit(input logic b);
    msg_valid_i = 1'b1;
    msg_bit_i   = b;
    while (!msg_ready_o) @(negedge clk);
    @(negedge clk);
    msg_valid_i = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  // Waits for chip 0, then gathers 11 chips; entered and left at a negedge.
  task automatic get_sym(output logic [10:0] w, output int gap, output bit frame_ok,
                         output logic rdy_mid);
    gap = 0;
    frame_ok = 1'b1;
    rdy_mid = 1'b1;
    w = '0;
    while (!(chip_stb_o && sym_start_o)) begin
      gap++;
      @(negedge clk);
    end
    for (int i = 0; i < 11; i++) begin
      if (!chip_stb_o || (sym_start_o != (i == 0))) frame_ok = 1'b0;
      if (!(chip_o == 2'sd1 || chip_o == -2'sd1)) frame_ok = 1'b0;
      if (phase_sel_o != (chip_o == -2'sd1)) frame_ok = 1'b0;
      w[10 - i] = (chip_o == 2'sd1);
      if (i == 5) rdy_mid = msg_ready_o;
      @(negedge clk);
    end
  endtask

  task automatic bank_write(input int a, input logic [10:0] d);
    cfg_we_i = 1'b1;
    cfg_addr_i = 3'(a);
    cfg_code_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // R11: reset state, zero bank
  task automatic t_reset;
    logic [10:0] w; int gap; bit fok; logic rm;
    check(chip_stb_o == 1'b0, "R11 strobe after reset", chip_stb_o, 0);
    check(sym_start_o == 1'b0, "R11 start after reset", sym_start_o, 0);
    check(msg_ready_o == 1'b1, "R11 ready after reset", msg_ready_o, 1);
    check(chip_o == 2'sd0, "R4 idle chip zero", chip_o, 0);
    mode_i = 2'd1;
    fork
      send_bit(1'b1);
      get_sym(w, gap, fok, rm);
    join
    check(w == 11'h000, "R11 bank entry reads zero", w, 0);
    check(fok, "R9 R4 R5 framing of zero code", fok, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_load_bank;
    for (int k = 0; k < 8; k++) begin
      exp_bank[k] = mk_code(k);
      bank_write(k, exp_bank[k]);
    end
    repeat (2) @(negedge clk);
  endtask

  // R1 R2 R3 R5 R7 R9: a stream of nsym symbols in one mode
  task automatic t_stream(input logic [1:0] m, input int nsym, input logic [31:0] v, input string tag);
    int need;
    need = (m == 2'd0) ? 1 : int'(m);
    mode_i = m;
    fork
      send_bits(v, nsym * need);
      begin
        for (int s = 0; s < nsym; s++) begin
          logic [10:0] w; int gap; bit fok; logic rm; int idx;
          idx = int'((v >> ((nsym - 1 - s) * need)) & ((1 << need) - 1));
          get_sym(w, gap, fok, rm);
          check(w == exp_bank[idx], {"R1 R2 R3 code for index ", tag}, w, exp_bank[idx]);
          check(fok, {"R9 R4 R5 chip framing ", tag}, fok, 1);
          if (s > 0) check(gap == 0, {"R7 back-to-back symbols ", tag}, gap, 0);
          if (s == 1 && nsym >= 3)
            check(rm == 1'b0, {"R7 input held while symbol waits ", tag}, rm, 0);
        end
      end
    join
  endtask

  // R8: drained stream goes idle
  task automatic t_idle;
    bit quiet = 1'b1;
    for (int i = 0; i < 25; i++) begin
      if (chip_stb_o || sym_start_o || chip_o != 2'sd0 || phase_sel_o) quiet = 1'b0;
      @(negedge clk);
    end
    check(quiet, "R8 idle, no repeat of last code", quiet, 1);
  endtask

  // R6: mode change in the middle of a symbol
  task automatic t_mode_mid;
    logic [10:0] w1, w2; int g; bit f1, f2; logic rm;
    fork
      begin
        mode_i = 2'd3;
        send_bit(1'b1);
        mode_i = 2'd1;
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
      end
      begin
        get_sym(w1, g, f1, rm);
        get_sym(w2, g, f2, rm);
      end
    join
    check(w1 == exp_bank[5], "R6 mode held for the running symbol", w1, exp_bank[5]);
    check(w2 == exp_bank[0], "R6 new mode at the next symbol", w2, exp_bank[0]);
  endtask

  // R10: write during a transmission ignored, write while idle taken
  task automatic t_write_guard;
    logic [10:0] w; int g; bit f; logic rm;
    logic [10:0] fresh;
    mode_i = 2'd1;
    fork
      send_bit(1'b0);
      get_sym(w, g, f, rm);
      begin
        while (!chip_stb_o) @(negedge clk);
        repeat (3) @(negedge clk);
        bank_write(1, ~exp_bank[1]);
      end
    join
    check(w == exp_bank[0], "R10 running code unchanged", w, exp_bank[0]);
    repeat (3) @(negedge clk);
    fork
      send_bit(1'b1);
      get_sym(w, g, f, rm);
    join
    check(w == exp_bank[1], "R10 write while strobing ignored", w, exp_bank[1]);
    repeat (3) @(negedge clk);
    fresh = 11'h5A3;
    bank_write(7, fresh);
    exp_bank[7] = fresh;
    mode_i = 2'd3;
    fork
      send_bits(32'h7, 3);
      get_sym(w, g, f, rm);
    join
    check(w == fresh, "R10 write while idle stored", w, fresh);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_bank();
    t_stream(2'd1, 4, 32'b1011, "mode1");
    t_idle();
    t_stream(2'd2, 3, 32'b10_01_11, "mode2");
    t_idle();
    t_stream(2'd3, 3, 32'b110_011_101, "mode3");
    t_idle();
    t_stream(2'd0, 2, 32'b10, "mode0");
    t_mode_mid();
    t_idle();
    t_write_guard();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule